// File: doc/BRIEF.md
# TDM Output Channel Source Selector

This block produces one serial output stream of a time-division switch. A bit counter and a channel counter step through the output frame, one bit per clock and eight bits per channel. For each output channel the block reads a connection entry, and that entry decides where the channel's byte comes from. In connection mode the entry's source field names an input stream and an input channel. The block turns these into a read address into a data memory that holds the captured input bytes. In message mode the low byte of the entry is itself the output byte, and the data memory is not read.

The way the source field is split between channel number and stream select depends on the configured line rate. At full rate there is no stream select. At half rate there is one select bit. At quarter rate and eighth rate there are two select bits, and at eighth rate one field bit is reserved. The channel count per frame shrinks with the rate in the same ratio. A frame pulse restarts the frame at channel 0. Both memories are simple arrays, each with its own write port.

Top module: `tdm_src_sel`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `ser_o` is 1, `err_o` is 0 and `chan_o` is 0.
- R2: When `fp_i` is high at a rising edge, the next cycle is bit 0 of channel 0, and that cycle carries the MSB of channel 0's byte. This holds wherever in a channel the pulse arrives.
- R3: Each channel lasts exactly 8 clocks. `ser_o` gives the channel's byte MSB first, `chan_o` holds the channel number for all 8 clocks, and after that `chan_o` goes up by one.
- R4: `rate_i` encodes full (00), half (01), quarter (10) and eighth (11) rate. The channel counter returns to 0 after channel 2^W/1, 2^W/2, 2^W/4 or 2^W/8 minus one respectively, where W = `SRC_W`.
- R5: At full rate, a connection entry with field F reads data memory address F.
- R6: At half rate, the data memory address is {F[0], F[W-1:1]}: the stream select bit F[0] is the address MSB, followed by the channel F[W-1:1].
- R7: At quarter rate, the data memory address is {F[1:0], F[W-1:2]}, with stream codes 00, 01, 10, 11 for streams A to D.
- R8: At eighth rate, the data memory address is {1'b0, F[1:0], F[W-1:3]}.
- R9: At eighth rate, a connection entry with F[2] = 1 makes the channel output all ones, and `err_o` is high for all 8 clocks of that channel. `err_o` is low otherwise.
- R10: A message entry (`cm_msg_i` = 1 when written) outputs F[7:0] at every rate. F[W-1:8] has no effect, F[2] raises no error, and the data memory contents do not matter.
- R11: The entry for channel N+1 is read during bit 7 of channel N. A connection memory write sampled at the edge that ends that bit is not seen by channel N+1, while a write sampled earlier is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fp_i | input | 1 | Frame pulse, restarts at channel 0 |
| rate_i | input | 2 | Line rate select: 00 full, 01 half, 10 quarter, 11 eighth |
| cm_we_i | input | 1 | Connection memory write enable |
| cm_addr_i | input | SRC_W | Output channel whose entry is written |
| cm_msg_i | input | 1 | Entry mode: 1 message, 0 connection |
| cm_fld_i | input | SRC_W | Source field / message byte |
| dm_we_i | input | 1 | Data memory write enable |
| dm_addr_i | input | SRC_W | Data memory write address ({stream, channel}) |
| dm_data_i | input | 8 | Data memory write byte |
| ser_o | output | 1 | Serial output bit |
| err_o | output | 1 | Reserved-bit error for the current channel |
| chan_o | output | SRC_W | Current output channel number |

## Verification
The bench builds the block with `SRC_W` = 8, the narrowest field that still holds a full message byte. With this value a full-rate frame is 256 channels and an eighth-rate frame is 32. Every rate's wrap point, including the step past the last channel, therefore fits in a few thousand cycles. It also means random source fields reach every stream-select code and every reserved-bit case many times.

// File: rtl/tdm_sel_pkg.sv
package tdm_sel_pkg;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] IDLE_BYTE = '1;

    typedef enum logic [1:0] {
        RATE_FULL    = 2'b00,
        RATE_HALF    = 2'b01,
        RATE_QUARTER = 2'b10,
        RATE_EIGHTH  = 2'b11
    } rate_e;

    // Byte and error flag chosen for one output channel
    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              err;
    } slot_t;

    // log2 of the channel-count divisor for a rate
    function automatic logic [1:0] rate_shift(rate_e r);
        case (r)
            RATE_FULL:    return 2'd0;
            RATE_HALF:    return 2'd1;
            RATE_QUARTER: return 2'd2;
            default:      return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/tdm_sel_timer.sv
module tdm_sel_timer
    import tdm_sel_pkg::*;
#(
    parameter int SRC_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fp,
    input  rate_e            rate,
    output logic [SRC_W-1:0] chan,
    output logic [2:0]       bit_pos,
    output logic             load,
    output logic [SRC_W-1:0] fetch_chan
);
    localparam logic [SRC_W:0] FULL_COUNT = {1'b1, {SRC_W{1'b0}}};

    logic [SRC_W:0]   limit;
    logic [SRC_W:0]   succ;
    logic [SRC_W-1:0] next_chan;
    logic             last_bit;

    assign last_bit = (bit_pos == 3'd7);

    always_comb begin
        limit     = FULL_COUNT >> rate_shift(rate);
        succ      = {1'b0, chan} + 1'b1;
        next_chan = (succ >= limit) ? '0 : succ[SRC_W-1:0];
    end

    assign load       = fp | last_bit;
    assign fetch_chan = fp ? '0 : next_chan;

    always_ff @(posedge clk) begin
        if (rst || fp) begin
            chan    <= '0;
            bit_pos <= '0;
        end else begin
            bit_pos <= bit_pos + 3'd1;
            if (last_bit)
                chan <= next_chan;
        end
    end

endmodule

// File: rtl/tdm_sel_cmem.sv
module tdm_sel_cmem #(
    parameter int SRC_W = 10
) (
    input  logic             clk,
    input  logic             we,
    input  logic [SRC_W-1:0] waddr,
    input  logic             wmsg,
    input  logic [SRC_W-1:0] wfld,
    input  logic [SRC_W-1:0] raddr,
    output logic             rmsg,
    output logic [SRC_W-1:0] rfld
);
    localparam int DEPTH = 1 << SRC_W;

    logic [SRC_W:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= {wmsg, wfld};
    end

    assign {rmsg, rfld} = mem[raddr];

endmodule

// File: rtl/tdm_sel_dmem.sv
module tdm_sel_dmem
    import tdm_sel_pkg::*;
#(
    parameter int SRC_W = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [SRC_W-1:0]  waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [SRC_W-1:0]  raddr,
    output logic [BYTE_W-1:0] rdata
);
    localparam int DEPTH = 1 << SRC_W;

    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/tdm_sel_decode.sv
module tdm_sel_decode
    import tdm_sel_pkg::*;
#(
    parameter int SRC_W = 10
) (
    input  rate_e             rate,
    input  logic              msg,
    input  logic [SRC_W-1:0]  fld,
    output logic [SRC_W-1:0]  dm_addr,
    input  logic [BYTE_W-1:0] dm_rdata,
    output slot_t             slot
);
    logic reserved_hit;

    // Stream select moves to the top of the data memory address
    always_comb begin
        case (rate)
            RATE_FULL:    dm_addr = fld;
            RATE_HALF:    dm_addr = {fld[0], fld[SRC_W-1:1]};
            RATE_QUARTER: dm_addr = {fld[1:0], fld[SRC_W-1:2]};
            default:      dm_addr = {1'b0, fld[1:0], fld[SRC_W-1:3]};
        endcase
    end

    assign reserved_hit = (rate == RATE_EIGHTH) && !msg && fld[2];

    always_comb begin
        if (msg) begin
            slot.data = fld[BYTE_W-1:0];
            slot.err  = 1'b0;
        end else if (reserved_hit) begin
            slot.data = IDLE_BYTE;
            slot.err  = 1'b1;
        end else begin
            slot.data = dm_rdata;
            slot.err  = 1'b0;
        end
    end

endmodule

// File: rtl/tdm_sel_shifter.sv
module tdm_sel_shifter
    import tdm_sel_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  slot_t slot,
    output logic  ser,
    output logic  err
);
    logic [BYTE_W-1:0] sreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= IDLE_BYTE;
            err  <= 1'b0;
        end else if (load) begin
            sreg <= slot.data;
            err  <= slot.err;
        end else begin
            sreg <= {sreg[BYTE_W-2:0], 1'b1};
        end
    end

    assign ser = sreg[BYTE_W-1];

endmodule

// File: rtl/tdm_src_sel.sv
module tdm_src_sel
    import tdm_sel_pkg::*;
#(
    parameter int SRC_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fp_i,
    input  logic [1:0]       rate_i,
    input  logic             cm_we_i,
    input  logic [SRC_W-1:0] cm_addr_i,
    input  logic             cm_msg_i,
    input  logic [SRC_W-1:0] cm_fld_i,
    input  logic             dm_we_i,
    input  logic [SRC_W-1:0] dm_addr_i,
    input  logic [7:0]       dm_data_i,
    output logic             ser_o,
    output logic             err_o,
    output logic [SRC_W-1:0] chan_o
);
    rate_e             rate;
    logic [2:0]        bit_pos;
    logic              load;
    logic [SRC_W-1:0]  fetch_chan;
    logic              ent_msg;
    logic [SRC_W-1:0]  ent_fld;
    logic [SRC_W-1:0]  dm_raddr;
    logic [BYTE_W-1:0] dm_rdata;
    slot_t             slot;

    assign rate = rate_e'(rate_i);

    tdm_sel_timer #(.SRC_W(SRC_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .fp         (fp_i),
        .rate       (rate),
        .chan       (chan_o),
        .bit_pos    (bit_pos),
        .load       (load),
        .fetch_chan (fetch_chan)
    );

    tdm_sel_cmem #(.SRC_W(SRC_W)) u_cmem (
        .clk   (clk),
        .we    (cm_we_i),
        .waddr (cm_addr_i),
        .wmsg  (cm_msg_i),
        .wfld  (cm_fld_i),
        .raddr (fetch_chan),
        .rmsg  (ent_msg),
        .rfld  (ent_fld)
    );

    tdm_sel_decode #(.SRC_W(SRC_W)) u_decode (
        .rate     (rate),
        .msg      (ent_msg),
        .fld      (ent_fld),
        .dm_addr  (dm_raddr),
        .dm_rdata (dm_rdata),
        .slot     (slot)
    );

    tdm_sel_dmem #(.SRC_W(SRC_W)) u_dmem (
        .clk   (clk),
        .we    (dm_we_i),
        .waddr (dm_addr_i),
        .wdata (dm_data_i),
        .raddr (dm_raddr),
        .rdata (dm_rdata)
    );

    tdm_sel_shifter u_shift (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .slot (slot),
        .ser  (ser_o),
        .err  (err_o)
    );

endmodule

// File: rtl/tdm_src_sel_chk.sv
module tdm_src_sel_chk #(
    parameter int SRC_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             fp_i,
    input logic [1:0]       rate_i,
    input logic [2:0]       bit_pos,
    input logic             ser_o,
    input logic             err_o,
    input logic [SRC_W-1:0] chan_o
);
    // R1: idle outputs after reset
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (ser_o && !err_o && chan_o == '0));

    // R2: frame pulse restarts at channel 0, bit 0
    assert_frame_restart_R2: assert property (@(posedge clk) disable iff (rst)
        fp_i |=> (chan_o == '0 && bit_pos == 3'd0));

    // R3: inside a channel the number holds and the bit position steps
    assert_chan_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!fp_i && bit_pos != 3'd7) |=>
            ($stable(chan_o) && bit_pos == 3'($past(bit_pos) + 3'd1)));

    // R4: at a channel boundary the number steps by one or wraps to 0
    assert_chan_step_R4: assert property (@(posedge clk) disable iff (rst)
        (!fp_i && bit_pos == 3'd7) |=>
            (chan_o == '0 || chan_o == SRC_W'($past(chan_o) + 1'b1)));

    // R9: an error only starts from an eighth-rate fetch
    assert_err_eighth_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(err_o) |-> ($past(rate_i) == 2'b11));

    // R9: the error flag is held for the whole channel
    assert_err_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!fp_i && bit_pos != 3'd7) |=> $stable(err_o));

endmodule

bind tdm_src_sel tdm_src_sel_chk #(.SRC_W(SRC_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .fp_i    (fp_i),
    .rate_i  (rate_i),
    .bit_pos (bit_pos),
    .ser_o   (ser_o),
    .err_o   (err_o),
    .chan_o  (chan_o)
);

// File: tb/tdm_src_sel_tb.sv
module tdm_src_sel_tb;
    localparam int W = 8;
    localparam int N = 1 << W;

    typedef struct packed {
        logic [7:0]   data;
        logic         err;
        logic [W-1:0] chan;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         fp = 1'b0;
    logic [1:0]   rate = 2'b00;
    logic         cm_we = 1'b0;
    logic [W-1:0] cm_addr = '0;
    logic         cm_msg = 1'b0;
    logic [W-1:0] cm_fld = '0;
    logic         dm_we = 1'b0;
    logic [W-1:0] dm_addr = '0;
    logic [7:0]   dm_data = '0;
    logic         ser;
    logic         err;
    logic [W-1:0] chan;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    logic         sh_msg [N];
    logic [W-1:0] sh_fld [N];
    logic [7:0]   sh_dm  [N];

    exp_t  exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    tdm_src_sel #(.SRC_W(W)) u_dut (
        .clk(clk), .rst(rst), .fp_i(fp), .rate_i(rate),
        .cm_we_i(cm_we), .cm_addr_i(cm_addr), .cm_msg_i(cm_msg), .cm_fld_i(cm_fld),
        .dm_we_i(dm_we), .dm_addr_i(dm_addr), .dm_data_i(dm_data),
        .ser_o(ser), .err_o(err), .chan_o(chan)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    function automatic int chan_count(logic [1:0] r);
        return N >> r;
    endfunction

    // Expected byte from the requirements (R5..R10)
    function automatic exp_t model(int c, logic [1:0] r);
        exp_t e;
        logic [W-1:0] f;
        logic [W-1:0] a;
        f = sh_fld[c];
        e.chan = W'(c);
        e.err = 1'b0;
        if (sh_msg[c]) e.data = f[7:0];
        else if (r == 2'b11 && f[2]) begin e.data = 8'hFF; e.err = 1'b1; end
        else begin
            case (r)
                2'b00: a = f;
                2'b01: a = {f[0], f[W-1:1]};
                2'b10: a = {f[1:0], f[W-1:2]};
                default: a = {1'b0, f[1:0], f[W-1:3]};
            endcase
            e.data = sh_dm[a];
        end
        return e;
    endfunction

    function automatic string tag_of(int c, logic [1:0] r, bit wrapped);
        string t;
        if (sh_msg[c]) t = "R10";
        else if (r == 2'b11 && sh_fld[c][2]) t = "R9";
        else case (r)
            2'b00: t = "R5";
            2'b01: t = "R6";
            2'b10: t = "R7";
            default: t = "R8";
        endcase
        return wrapped ? {t, "/R4"} : {t, "/R3"};
    endfunction

    task automatic push(int c, logic [1:0] r, bit wrapped);
        exp_q.push_back(model(c, r));
        tag_q.push_back(tag_of(c, r, wrapped));
    endtask

    task automatic cm_write(int a, bit m, logic [W-1:0] f);
        @(negedge clk);
        cm_we = 1'b1; cm_addr = W'(a); cm_msg = m; cm_fld = f;
        @(negedge clk);
        cm_we = 1'b0;
        sh_msg[a] = m; sh_fld[a] = f;
    endtask

    task automatic fill_mem(int msg_pct);
        for (int a = 0; a < N; a++) begin
            @(negedge clk);
            dm_we = 1'b1; dm_addr = W'(a); dm_data = 8'($urandom);
            sh_dm[a] = dm_data;
        end
        @(negedge clk);
        dm_we = 1'b0;
        for (int a = 0; a < N; a++)
            cm_write(a, (($urandom % 100) < msg_pct), W'($urandom));
    endtask

    task automatic pulse_fp();
        @(negedge clk);
        fp = 1'b1;
        @(negedge clk);
        fp = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Observe a frame and two channels past its wrap point
    task automatic run_frame(logic [1:0] r);
        int n;
        @(negedge clk);
        rate = r;
        n = chan_count(r);
        for (int i = 0; i < n + 2; i++) push(i % n, r, i >= n);
        pulse_fp();
        drain();
    endtask

    // Monitor: collects 8 bits per channel after each frame pulse
    logic       fp_q = 1'b0;
    bit         mon_on = 0;
    int         k = 0;
    logic [7:0] acc;
    logic       err0;
    logic [W-1:0] ch0;
    bit         err_stable;

    always @(posedge clk) fp_q <= fp;

    always @(negedge clk) begin
        exp_t it;
        string tg;
        if (fp_q) begin
            mon_on = (exp_q.size() > 0);
            k = 0;
        end
        if (mon_on) begin
            acc = {acc[6:0], ser};
            if (k == 0) begin
                err0 = err; ch0 = chan; err_stable = 1;
            end else if (err !== err0 || chan !== ch0) begin
                err_stable = 0;
            end
            k++;
            if (k == 8) begin
                it = exp_q.pop_front();
                tg = tag_q.pop_front();
                check(acc == it.data, tg, "data", int'(acc), int'(it.data));
                check(err0 == it.err, tg, "err", int'(err0), int'(it.err));
                check(ch0 == it.chan, tg, "chan", int'(ch0), int'(it.chan));
                check(err_stable, "R3", "err/chan held over channel", 0, 1);
                k = 0;
                if (exp_q.size() == 0) mon_on = 0;
            end
        end
    end

    task automatic finish_up();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog expired");
            finish_up();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle state right after reset
        check(ser == 1'b1, "R1", "ser after reset", int'(ser), 1);
        check(err == 1'b0, "R1", "err after reset", int'(err), 0);
        check(chan == '0, "R1", "chan after reset", int'(chan), 0);

        fill_mem(25);
        run_frame(2'b00);   // R5, R10, R4 at full rate
        run_frame(2'b01);   // R6
        run_frame(2'b10);   // R7

        // Eighth rate: force reserved-bit cases in both modes (R8, R9, R10)
        cm_write(4, 1'b1, W'(8'h3C) | W'(8'hC4));
        cm_write(6, 1'b0, W'(8'h2D));
        cm_write(7, 1'b0, W'(8'h6B));
        cm_write(9, 1'b0, W'(8'h50));
        cm_write(31, 1'b0, W'(8'hF4));
        run_frame(2'b11);

        // R2: frame pulse in the middle of channel 3 restarts the frame
        @(negedge clk);
        rate = 2'b10;
        for (int c = 0; c < 3; c++) push(c, 2'b10, 0);
        pulse_fp();
        repeat (27) @(negedge clk);
        push(0, 2'b10, 0);
        exp_q[exp_q.size()-1].data = model(0, 2'b10).data;
        tag_q[tag_q.size()-1] = "R2";
        push(1, 2'b10, 0);
        fp = 1'b1;
        @(negedge clk);
        fp = 1'b0;
        drain();

        // R11: write at the fetch edge is missed, earlier write is seen
        cm_write(3, 1'b1, W'(8'h5A));
        @(negedge clk);
        rate = 2'b01;
        sh_msg[5] = 1'b1; sh_fld[5] = W'(8'h3C);
        for (int c = 0; c < 6; c++) begin
            push(c, 2'b01, 0);
            if (c == 3 || c == 5) tag_q[tag_q.size()-1] = "R11";
        end
        @(negedge clk);
        fp = 1'b1;
        @(negedge clk);
        fp = 1'b0;
        repeat (23) @(negedge clk);
        cm_we = 1'b1; cm_addr = W'(3); cm_msg = 1'b1; cm_fld = W'(8'hA5);
        @(negedge clk);
        cm_we = 1'b0;
        repeat (3) @(negedge clk);
        cm_we = 1'b1; cm_addr = W'(5); cm_msg = 1'b1; cm_fld = W'(8'h3C);
        @(negedge clk);
        cm_we = 1'b0;
        drain();
        sh_msg[3] = 1'b1; sh_fld[3] = W'(8'hA5);

        // Second pass with new contents and more message entries
        fill_mem(50);
        run_frame(2'b11);
        run_frame(2'b01);

        repeat (4) @(negedge clk);
        finish_up();
    end

endmodule